// File: doc/BRIEF.md
# I2C Command-Response Slave Front End

This block is the bus-facing part of a device that takes commands over I2C and returns responses. It samples the serial clock and data lines through synchronisers in the system clock domain. It detects start, repeated start and stop conditions. It decodes the address byte and acknowledges the bytes it accepts. The pads are modelled as two drive-low enables plus the two sampled line inputs. The open-drain wiring lives outside the block.

A master first writes a command. Each received byte is handed to a command sink as a one-cycle strobe. The master then reads the answer. After acknowledging the read address, the block holds the clock line low until the internal responder signals that data is ready. It then shifts the response bytes out, most significant bit first, pulling a new byte from the responder for every byte the master acknowledges.

The bus address of the block comes from three address pins when they are nonzero. When the pins read all zeros, it comes from a stored configuration value.

Top module: `i2c_cr_slave`

## Requirements
- R1: The address byte is matched as bits 7..4 = 4'b1010, bits 3..1 = effective address, and bit 0 = direction (0 = command write, 1 = response read). On a match the block pulls SDA low during the ninth clock.
- R2: The effective address is `pin_addr_i` when it is nonzero and `cfg_addr_i` when `pin_addr_i` is 3'b000.
- R3: An address byte with the wrong device code or a non-matching address gets no acknowledge. The block then stays idle until the next start.
- R4: In a write transaction, every data byte is acknowledged. Each byte is presented on `cmd_data_o` with a one-cycle `cmd_valid_o`, in arrival order. `cmd_first_o` is set only for the first byte of the transaction.
- R5: A read address that arrives when no command is pending gets no acknowledge, and no response byte is taken.
- R6: After acknowledging a read address, the block drives SCL low while `resp_ready_i` is 0. It releases SCL once `resp_ready_i` is 1.
- R7: Response bytes are captured from `resp_data_i` with a one-cycle `resp_take_o` and sent MSB first. SDA changes only while SCL is low.
- R8: A command is pending from the end of a write transaction that delivered at least one byte until the next accepted read. Bytes of further write transactions during that time are acknowledged but not delivered.
- R9: After the master NACKs a response byte, no further byte is taken and SDA stays released until a stop or start.
- R10: A stop condition during a read returns the block to idle, even when it arrives in place of the master's acknowledge bit.
- R11: A repeated start ends a write transaction just as a stop does, so a command followed directly by a repeated-start read gets its response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| pin_addr_i | input | 3 | Address pins; 000 selects the stored address |
| cfg_addr_i | input | 3 | Stored slave address |
| scl_lo_o | output | 1 | Drive SCL low (clock stretch) |
| sda_lo_o | output | 1 | Drive SDA low (acknowledge or data 0) |
| cmd_valid_o | output | 1 | One-cycle strobe for a received command byte |
| cmd_data_o | output | 8 | Received command byte |
| cmd_first_o | output | 1 | Byte is the first of its write transaction |
| resp_ready_i | input | 1 | Responder has data ready |
| resp_data_i | input | 8 | Next response byte |
| resp_take_o | output | 1 | One-cycle strobe: `resp_data_i` captured |

## Verification
The hardest situation to reach is a stop condition that replaces the acknowledge bit of a response byte. At that moment the block has just released SDA and is waiting to sample the acknowledge. The bench master clocks eight data bits, then lowers SDA and raises SCL as if to acknowledge, and raises SDA while SCL is high. A follow-up read with no new command must then be refused. The bench also reaches the stretch by holding the responder not-ready while the master releases SCL, so it can watch the wired line stay low.

// File: rtl/i2c_cr_pkg.sv
package i2c_cr_pkg;
    localparam int          BYTE_W   = 8;
    localparam int          ADDR_W   = 3;
    localparam int          CNT_W    = $clog2(BYTE_W + 1);
    localparam logic [3:0]  DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_RX, ST_ACK, ST_STRETCH, ST_TX, ST_TX_ACK, ST_WAIT
    } slv_state_e;

    function automatic logic [ADDR_W-1:0] eff_addr(input logic [ADDR_W-1:0] pins,
                                                   input logic [ADDR_W-1:0] cfg);
        return (pins != '0) ? pins : cfg;
    endfunction

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                      input logic [ADDR_W-1:0] a);
        return (b[7:4] == DEV_CODE) && (b[3:1] == a);
    endfunction
endpackage

// File: rtl/i2c_cr_sync.sv
module i2c_cr_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) st[0] <= '1;
                else     st[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) st[g] <= '1;
                else     st[g] <= st[g-1];
            end
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/i2c_cr_cond.sv
module i2c_cr_cond (
    input  logic clk,
    input  logic rst,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_cr_slave.sv
module i2c_cr_slave
    import i2c_cr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [ADDR_W-1:0] pin_addr_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    output logic              scl_lo_o,
    output logic              sda_lo_o,
    output logic              cmd_valid_o,
    output logic [BYTE_W-1:0] cmd_data_o,
    output logic              cmd_first_o,
    input  logic              resp_ready_i,
    input  logic [BYTE_W-1:0] resp_data_i,
    output logic              resp_take_o
);
    logic [1:0]        lines_s;
    logic              scl_s, sda_s;
    logic              scl_rise, scl_fall, start_det, stop_det;
    slv_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sr;
    logic              rd, pending, take_cmd, got_byte, acked;

    i2c_cr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d({scl_i, sda_i}), .q(lines_s)
    );
    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    i2c_cr_cond u_cond (
        .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;  cnt <= '0;  sr <= '0;  rd <= 1'b0;
            pending <= 1'b0;  take_cmd <= 1'b0;  got_byte <= 1'b0;  acked <= 1'b0;
            scl_lo_o <= 1'b0;  sda_lo_o <= 1'b0;
            cmd_valid_o <= 1'b0;  cmd_data_o <= '0;  cmd_first_o <= 1'b0;
            resp_take_o <= 1'b0;
        end else begin
            cmd_valid_o <= 1'b0;
            resp_take_o <= 1'b0;
            if (start_det || stop_det) begin
                if (take_cmd && got_byte) pending <= 1'b1;
                take_cmd <= 1'b0;
                got_byte <= 1'b0;
                cnt      <= '0;
                sda_lo_o <= 1'b0;
                scl_lo_o <= 1'b0;
                state    <= start_det ? ST_ADDR : ST_IDLE;
            end else begin
                unique case (state)
                    ST_ADDR, ST_RX: begin
                        if (scl_rise) begin
                            sr  <= {sr[BYTE_W-2:0], sda_s};
                            cnt <= cnt + 1'b1;
                        end
                        if (scl_fall && cnt == CNT_W'(BYTE_W)) begin
                            cnt <= '0;
                            if (state == ST_ADDR) begin
                                if (addr_hit(sr, eff_addr(pin_addr_i, cfg_addr_i)) &&
                                    (!sr[0] || pending)) begin
                                    sda_lo_o <= 1'b1;
                                    rd       <= sr[0];
                                    state    <= ST_ACK;
                                    if (sr[0]) pending  <= 1'b0;
                                    else       take_cmd <= !pending;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                sda_lo_o <= 1'b1;
                                state    <= ST_ACK;
                                if (take_cmd) begin
                                    cmd_valid_o <= 1'b1;
                                    cmd_data_o  <= sr;
                                    cmd_first_o <= !got_byte;
                                    got_byte    <= 1'b1;
                                end
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            sda_lo_o <= 1'b0;
                            if (rd) begin
                                scl_lo_o <= 1'b1;
                                state    <= ST_STRETCH;
                            end else begin
                                state <= ST_RX;
                            end
                        end
                    end
                    ST_STRETCH: begin
                        if (resp_ready_i) begin
                            sr          <= resp_data_i;
                            sda_lo_o    <= ~resp_data_i[BYTE_W-1];
                            resp_take_o <= 1'b1;
                            scl_lo_o    <= 1'b0;
                            cnt         <= '0;
                            state       <= ST_TX;
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) cnt <= cnt + 1'b1;
                        if (scl_fall) begin
                            if (cnt == CNT_W'(BYTE_W)) begin
                                sda_lo_o <= 1'b0;
                                cnt      <= '0;
                                acked    <= 1'b0;
                                state    <= ST_TX_ACK;
                            end else begin
                                sr       <= {sr[BYTE_W-2:0], 1'b0};
                                sda_lo_o <= ~sr[BYTE_W-2];
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) acked <= ~sda_s;
                        if (scl_fall) begin
                            if (acked) begin
                                sr          <= resp_data_i;
                                sda_lo_o    <= ~resp_data_i[BYTE_W-1];
                                resp_take_o <= 1'b1;
                                state       <= ST_TX;
                            end else begin
                                state <= ST_WAIT;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R6: the clock stretch begins only as the read-address acknowledge ends
    p_stretch_entry_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_lo_o) |-> $past(state) == ST_ACK);

    // R6: a ready responder ends the stretch on the next cycle
    p_stretch_release_r6: assert property (@(posedge clk) disable iff (rst)
        (scl_lo_o && state == ST_STRETCH && resp_ready_i && !start_det && !stop_det)
        |=> !scl_lo_o);

    // R4: command strobes are single-cycle
    p_cmd_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_o |=> !cmd_valid_o);

    // R10: a stop releases both lines
    p_stop_release_r10: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> (!sda_lo_o && !scl_lo_o && state == ST_IDLE));

    // R9: after a NACK nothing is taken and SDA stays released
    p_nack_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        state == ST_WAIT |-> (!sda_lo_o && !resp_take_o));
endmodule

// File: tb/i2c_cr_slave_tb.sv
module i2c_cr_slave_tb;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic [2:0] pin_addr = 3'b000, cfg_addr = 3'b010;
    logic       scl_lo, sda_lo, cmd_valid, cmd_first, resp_ready = 1'b1, resp_take;
    logic [7:0] cmd_data, resp_data;
    logic       scl_line, sda_line;

    assign scl_line = scl_m & ~scl_lo;
    assign sda_line = sda_m & ~sda_lo;

    logic [7:0] resp_mem [8];
    int         take_cnt = 0;
    assign resp_data = resp_mem[take_cnt % 8];

    i2c_cr_slave u_dut (
        .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
        .pin_addr_i(pin_addr), .cfg_addr_i(cfg_addr),
        .scl_lo_o(scl_lo), .sda_lo_o(sda_lo),
        .cmd_valid_o(cmd_valid), .cmd_data_o(cmd_data), .cmd_first_o(cmd_first),
        .resp_ready_i(resp_ready), .resp_data_i(resp_data), .resp_take_o(resp_take)
    );

    int checks = 0, fails = 0;
    logic [8:0] exp_q[$];
    bit   done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock reference comparison of the command sink and responder strobes
    always @(negedge clk) begin
        if (!rst && resp_take) take_cnt++;
        if (!rst && cmd_valid) begin
            if (exp_q.size() == 0) chk(0, "R8 unexpected command byte", {cmd_first, cmd_data}, 0);
            else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                chk({cmd_first, cmd_data} == e, "R4 command byte", {cmd_first, cmd_data}, e);
            end
        end
    end

    int wd = 0;
    always @(negedge clk) begin
        wd++;
        if (wd > 150000 && !done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic wq(input int n); repeat (n) @(negedge clk); endtask
    task automatic scl_up(); scl_m = 1'b1; while (!scl_line) @(negedge clk); endtask

    task automatic bus_start();
        sda_m = 1; wq(Q); scl_up(); wq(Q); sda_m = 0; wq(Q); scl_m = 0; wq(Q);
    endtask
    task automatic bus_stop();
        sda_m = 0; wq(Q); scl_up(); wq(Q); sda_m = 1; wq(Q);
    endtask
    task automatic put_bit(input bit b);
        sda_m = b; wq(Q); scl_up(); wq(Q); scl_m = 0; wq(Q);
    endtask
    task automatic get_bit(output bit b);
        sda_m = 1; wq(Q); scl_up(); wq(Q/2); b = sda_line; wq(Q/2); scl_m = 0; wq(Q);
    endtask
    task automatic write_byte(input logic [7:0] d, output bit ack);
        bit s;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(s);
        ack = ~s;
    endtask
    task automatic read_bits(output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            bit b;
            get_bit(b);
            d[i] = b;
        end
    endtask

    initial begin
        bit ack;
        logic [7:0] d;
        int t0;
        for (int i = 0; i < 8; i++) resp_mem[i] = 8'(8'hC5 + i * 8'h17);
        wq(5);
        chk(sda_lo == 0 && scl_lo == 0 && cmd_valid == 0, "reset outputs",
            {sda_lo, scl_lo, cmd_valid}, 0);
        rst = 0; wq(5);

        // R1 R4: stored address, command of two bytes
        bus_start();
        write_byte({4'b1010, 3'b010, 1'b0}, ack); chk(ack, "R1 address ack", ack, 1);
        exp_q.push_back({1'b1, 8'h3C}); exp_q.push_back({1'b0, 8'h5A});
        write_byte(8'h3C, ack); chk(ack, "R4 data ack", ack, 1);
        write_byte(8'h5A, ack); chk(ack, "R4 data ack", ack, 1);
        bus_stop();
        chk(exp_q.size() == 0, "R4 bytes delivered", exp_q.size(), 0);

        // R6 R7 R9: stretched read, two bytes, NACK, then quiet
        resp_ready = 0;
        bus_start();
        write_byte({4'b1010, 3'b010, 1'b1}, ack); chk(ack, "R1 read address ack", ack, 1);
        sda_m = 1; wq(Q); scl_m = 1; wq(40);
        chk(scl_line == 0, "R6 clock held low", scl_line, 0);
        resp_ready = 1; while (!scl_line) @(negedge clk);
        wq(Q/2); d[7] = sda_line; wq(Q/2); scl_m = 0; wq(Q);
        for (int i = 6; i >= 0; i--) begin bit b; get_bit(b); d[i] = b; end
        chk(d == resp_mem[0], "R7 first response byte", d, resp_mem[0]);
        put_bit(0);
        read_bits(d); chk(d == resp_mem[1], "R7 second response byte", d, resp_mem[1]);
        put_bit(1);
        read_bits(d); chk(d == 8'hFF, "R9 released after NACK", d, 8'hFF);
        chk(take_cnt == 2, "R9 no take after NACK", take_cnt, 2);
        bus_stop();

        // R5: read with nothing pending
        bus_start();
        write_byte({4'b1010, 3'b010, 1'b1}, ack); chk(!ack, "R5 read refused", ack, 0);
        bus_stop();

        // R2: pins override stored address
        pin_addr = 3'b101;
        bus_start();
        write_byte({4'b1010, 3'b010, 1'b0}, ack); chk(!ack, "R2 stored address ignored", ack, 0);
        bus_stop();
        bus_start();
        write_byte({4'b1010, 3'b101, 1'b0}, ack); chk(ack, "R2 pin address ack", ack, 1);
        exp_q.push_back({1'b1, 8'h11});
        write_byte(8'h11, ack);
        bus_stop();

        // R8: second command while first is pending is dropped
        bus_start();
        write_byte({4'b1010, 3'b101, 1'b0}, ack); chk(ack, "R8 address ack", ack, 1);
        write_byte(8'h22, ack); chk(ack, "R8 dropped byte still acked", ack, 1);
        bus_stop();
        chk(exp_q.size() == 0, "R8 queue", exp_q.size(), 0);
        t0 = take_cnt;
        bus_start();
        write_byte({4'b1010, 3'b101, 1'b1}, ack); chk(ack, "R8 pending read ack", ack, 1);
        read_bits(d); chk(d == resp_mem[t0 % 8], "R8 response", d, resp_mem[t0 % 8]);
        put_bit(1); bus_stop();

        // R11: write then repeated-start read
        bus_start();
        write_byte({4'b1010, 3'b101, 1'b0}, ack);
        exp_q.push_back({1'b1, 8'h33});
        write_byte(8'h33, ack);
        t0 = take_cnt;
        bus_start();
        write_byte({4'b1010, 3'b101, 1'b1}, ack); chk(ack, "R11 repeated start read ack", ack, 1);
        read_bits(d); chk(d == resp_mem[t0 % 8], "R11 response", d, resp_mem[t0 % 8]);
        put_bit(1); bus_stop();

        // R3: wrong device code
        bus_start();
        write_byte({4'b1011, 3'b101, 1'b0}, ack); chk(!ack, "R3 wrong code", ack, 0);
        bus_stop();

        // R10: stop in place of the acknowledge bit
        bus_start();
        write_byte({4'b1010, 3'b101, 1'b0}, ack);
        exp_q.push_back({1'b1, 8'h44});
        write_byte(8'h44, ack);
        bus_stop();
        bus_start();
        write_byte({4'b1010, 3'b101, 1'b1}, ack); chk(ack, "R10 read ack", ack, 1);
        read_bits(d);
        t0 = take_cnt;
        bus_stop();
        wq(20);
        chk(take_cnt == t0 && sda_lo == 0, "R10 idle after stop", take_cnt, t0);
        bus_start();
        write_byte({4'b1010, 3'b101, 1'b1}, ack); chk(!ack, "R10 no pending after stop", ack, 0);
        bus_stop();
        chk(exp_q.size() == 0, "R4 final queue", exp_q.size(), 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule